// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Stage

This block turns bytes written by a host into asynchronous serial frames. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a high stop period. Timing comes from `baud_tick`, an enable pulse at sixteen times the bit rate, so every bit lasts sixteen ticks. Bytes wait in a buffer in front of the shift register. In character mode that buffer holds a single entry and acts as a holding register. In FIFO mode it holds up to sixteen entries.

The frame shape is taken from the configuration pins at the moment a byte moves from the buffer into the shift register, and it stays fixed until that frame ends. The block raises `thr_irq` part way through the stop period of a frame if nothing is left to send. A write clears `thr_irq`. `tx_ready` tells the host that a write will be accepted. Asserting `break_en` pulls the line low at once. Framing keeps running underneath, so the frame that is in flight stays on schedule when break is released.

Top module: `utx_core`

## Requirements
- R1: After reset, `txd` is 1, `thr_irq` is 0 and `tx_ready` is 1.
- R2: A frame is sent as a 0 start bit, the data bits least significant bit first, the parity bit if enabled, and then the stop level 1. Every bit except the stop period lasts 16 `baud_tick` pulses.
- R3: `data_bits` selects the character width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `wr_data` above the selected width are not sent.
- R4: When `parity_en` is 1, a parity bit follows the data. With `parity_even`=1 the data plus parity hold an even number of ones. With `parity_even`=0 they hold an odd number. When `parity_en` is 0, no parity bit is sent.
- R5: The stop period lasts 16 ticks when `stop_long`=0. When `stop_long`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6 to 8-bit characters.
- R6: When the shifter is idle and a byte is written, the start bit begins between 8 and 24 ticks after the write.
- R7: If another byte is waiting when a stop period ends, its start bit follows on the very next tick, with no idle gap.
- R8: In character mode (`fifo_mode`=0) the buffer holds one byte. In FIFO mode it holds 16 bytes, sent in write order. `tx_ready` is 0 exactly when the buffer is full, and a write made while it is full is dropped.
- R9: `thr_irq` rises 8 ticks after the stop period begins, provided no byte is waiting. Any accepted write clears it, and a write in the same cycle as the rise takes precedence.
- R10: While `break_en` is 1, `txd` is 0. Bit timing keeps running, so the bits after release and the stop period fall at their normal times.
- R11: Without `baud_tick` pulses the shifter does not advance: `txd` stays at its current level and a written byte stays buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to transmit |
| fifo_mode | input | 1 | 1: 16-entry buffer, 0: single holding entry |
| data_bits | input | 2 | Character width code (0..3 means 5..8 bits) |
| parity_en | input | 1 | Send a parity bit |
| parity_even | input | 1 | 1: even parity, 0: odd parity |
| stop_long | input | 1 | 0: 1 stop bit, 1: 1.5 (5-bit) or 2 stop bits |
| break_en | input | 1 | Force the line low |
| txd | output | 1 | Serial line |
| thr_irq | output | 1 | Buffer-empty interrupt |
| tx_ready | output | 1 | A write will be accepted |

## Verification
Two events can land in the same clock cycle: the host write that clears `thr_irq`, and the eighth tick of a stop period that sets it. The bench times a write so that it is sampled on exactly the edge where the interrupt would rise with an empty buffer. It then expects `thr_irq` to stay low and the new byte to follow straight after the stop period with no gap. A second overlap places break on top of a frame in flight. There the bench checks that the line is low during break, that the later data bits and the stop period appear at their normal times, and that the interrupt still rises at stop plus eight ticks.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int START_DELAY   = 8;
    localparam int IRQ_OFFSET    = 8;
    localparam int CNT_W         = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0]       wsel;
        logic             par_en;
        logic             par_bit;
        logic [CNT_W-1:0] stop_last;
    } frame_cfg_t;

    function automatic logic [CNT_W-1:0] stop_last_tick(input logic [1:0] wsel,
                                                        input logic stop_long);
        if (!stop_long)
            return CNT_W'(TICKS_PER_BIT - 1);
        else if (wsel == 2'd0)
            return CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
        else
            return CNT_W'(2 * TICKS_PER_BIT - 1);
    endfunction

    function automatic logic calc_parity(input logic [7:0] d, input logic [1:0] wsel,
                                         input logic even);
        logic [7:0] mask;
        mask = 8'hFF >> (3 - wsel);
        return (^(d & mask)) ^ ~even;
    endfunction

endpackage

// File: rtl/utx_buf.sv
module utx_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fifo_mode,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic [CW-1:0] cap;
    logic          push;

    assign cap   = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign full  = (count >= cap);
    assign empty = (count == '0);
    assign push  = push_req && !full;
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_data;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop && !empty)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/utx_shift.sv
module utx_shift
    import utx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       have_data,
    input  logic [7:0] next_data,
    input  logic [1:0] data_bits,
    input  logic       parity_en,
    input  logic       parity_even,
    input  logic       stop_long,
    output logic       pop,
    output logic       irq_pulse,
    output logic       line
);
    tx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       idx;
    logic [7:0]       sh;
    frame_cfg_t       cfg;
    logic             bit_end;

    assign bit_end = (cnt == CNT_W'(TICKS_PER_BIT - 1));

    assign pop = tick && have_data &&
                 ((state == ST_IDLE && cnt == CNT_W'(START_DELAY - 1)) ||
                  (state == ST_STOP && cnt == cfg.stop_last));

    assign irq_pulse = tick && !have_data && state == ST_STOP &&
                       cnt == CNT_W'(IRQ_OFFSET - 1);

    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = sh[0];
            ST_PAR:   line = cfg.par_bit;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            cfg   <= '0;
        end else if (tick) begin
            if (pop) begin
                state         <= ST_START;
                cnt           <= '0;
                sh            <= next_data;
                cfg.wsel      <= data_bits;
                cfg.par_en    <= parity_en;
                cfg.par_bit   <= calc_parity(next_data, data_bits, parity_even);
                cfg.stop_last <= stop_last_tick(data_bits, stop_long);
            end else begin
                case (state)
                    ST_IDLE: cnt <= have_data ? cnt + 1'b1 : '0;
                    ST_START: begin
                        cnt <= bit_end ? '0 : cnt + 1'b1;
                        if (bit_end) begin
                            state <= ST_DATA;
                            idx   <= '0;
                        end
                    end
                    ST_DATA: begin
                        cnt <= bit_end ? '0 : cnt + 1'b1;
                        if (bit_end) begin
                            sh  <= sh >> 1;
                            idx <= idx + 1'b1;
                            if (idx == 3'(3'd4 + {1'b0, cfg.wsel}))
                                state <= cfg.par_en ? ST_PAR : ST_STOP;
                        end
                    end
                    ST_PAR: begin
                        cnt <= bit_end ? '0 : cnt + 1'b1;
                        if (bit_end) state <= ST_STOP;
                    end
                    ST_STOP: begin
                        if (cnt == cfg.stop_last) begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/utx_core.sv
module utx_core #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_mode,
    input  logic [1:0] data_bits,
    input  logic       parity_en,
    input  logic       parity_even,
    input  logic       stop_long,
    input  logic       break_en,
    output logic       txd,
    output logic       thr_irq,
    output logic       tx_ready
);
    logic [7:0] head;
    logic       empty, full, pop, irq_pulse, line;

    utx_buf #(.DEPTH(DEPTH), .W(8)) i_buf (
        .clk       (clk),
        .rst       (rst),
        .fifo_mode (fifo_mode),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    utx_shift i_shift (
        .clk         (clk),
        .rst         (rst),
        .tick        (baud_tick),
        .have_data   (!empty),
        .next_data   (head),
        .data_bits   (data_bits),
        .parity_en   (parity_en),
        .parity_even (parity_even),
        .stop_long   (stop_long),
        .pop         (pop),
        .irq_pulse   (irq_pulse),
        .line        (line)
    );

    always_ff @(posedge clk) begin
        if (rst)
            thr_irq <= 1'b0;
        else if (wr_en && !full)
            thr_irq <= 1'b0;
        else if (irq_pulse)
            thr_irq <= 1'b1;
    end

    assign txd      = break_en ? 1'b0 : line;
    assign tx_ready = !full;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic wr_en,
    input logic fifo_mode,
    input logic break_en,
    input logic txd,
    input logic thr_irq,
    input logic tx_ready
);
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        break_en |-> !txd); // R10

    AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_ready) |=> !thr_irq); // R9

    AST_IRQ_IN_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(thr_irq) |-> (txd || break_en)); // R9

    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode && wr_en && tx_ready) |=> !tx_ready); // R8

    AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && !break_en && $past(!break_en) && $past(!rst)) |-> $stable(txd)); // R11
endmodule

bind utx_core utx_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .wr_en     (wr_en),
    .fifo_mode (fifo_mode),
    .break_en  (break_en),
    .txd       (txd),
    .thr_irq   (thr_irq),
    .tx_ready  (tx_ready)
);

// File: tb/test_utx_core.sv
module test_utx_core;
    logic       clk = 0, rst = 1, baud_tick = 0, wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       fifo_mode = 0, parity_en = 0, parity_even = 0, stop_long = 0, break_en = 0;
    logic [1:0] data_bits = 2'd3;
    logic       txd, thr_irq, tx_ready;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    utx_core i_utx_core (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_mode(fifo_mode), .data_bits(data_bits), .parity_en(parity_en),
        .parity_even(parity_even), .stop_long(stop_long), .break_en(break_en),
        .txd(txd), .thr_irq(thr_irq), .tx_ready(tx_ready)
    );

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] w;
        logic       pe;
        logic       ev;
        logic       sl;
        logic [8:0] total;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 9'd160},
        '{8'h3C, 2'd3, 1'b1, 1'b1, 1'b1, 9'd192},
        '{8'h13, 2'd0, 1'b1, 1'b0, 1'b1, 9'd136},
        '{8'h2A, 2'd1, 1'b1, 1'b1, 1'b0, 9'd144},
        '{8'h7F, 2'd2, 1'b0, 1'b0, 1'b1, 9'd160},
        '{8'hFF, 2'd0, 1'b0, 1'b0, 1'b1, 9'd120},
        '{8'h00, 2'd3, 1'b1, 1'b0, 1'b0, 9'd176}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_fall(output int t);
        int guard = 0;
        while (txd !== 1'b0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        t = cyc;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Called at the first negedge of a start bit. Returns the character and the parity seen.
    task automatic decode(input int n, input bit pe, output logic [7:0] got, output logic pgot,
                          output logic stop_lvl, output logic start_lvl);
        got = 0; pgot = 0;
        repeat (8) @(negedge clk);
        start_lvl = txd;
        for (int i = 0; i < n; i++) begin
            repeat (16) @(negedge clk);
            got[i] = txd;
        end
        if (pe) begin
            repeat (16) @(negedge clk);
            pgot = txd;
        end
        repeat (16) @(negedge clk);
        stop_lvl = txd;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, mask;
        logic       pg, sl, st, quiet;
        int         t1, t2, t0, n;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 thr_irq", thr_irq, 0);
        chk("R1 tx_ready", tx_ready, 1);

        // Table of frame shapes, two identical frames back to back per entry
        fifo_mode = 1;
        for (int v = 0; v < 7; v++) begin
            baud_tick = 0;
            data_bits = VECS[v].w; parity_en = VECS[v].pe;
            parity_even = VECS[v].ev; stop_long = VECS[v].sl;
            write_byte(VECS[v].d);
            write_byte(VECS[v].d);
            baud_tick = 1;
            n = 5 + VECS[v].w;
            mask = 8'hFF >> (3 - VECS[v].w);
            wait_fall(t1);
            decode(n, VECS[v].pe, got, pg, sl, st);
            chk("R2 start bit", st, 0);
            chk("R3 data width", got, VECS[v].d & mask);
            if (VECS[v].pe)
                chk("R4 parity", pg, (^(VECS[v].d & mask)) ^ !VECS[v].ev);
            chk("R2 stop level", sl, 1);
            wait_fall(t2);
            chk("R5 frame length with stop period", t2 - t1, VECS[v].total);
            decode(n, VECS[v].pe, got, pg, sl, st);
            chk("R7 second frame data", got, VECS[v].d & mask);
            repeat (40) @(negedge clk);
        end

        // R8 FIFO depth and ordering
        baud_tick = 0; data_bits = 3; parity_en = 0; stop_long = 0;
        for (int i = 0; i < 16; i++) write_byte(8'(8'h30 + i));
        chk("R8 fifo full ready", tx_ready, 0);
        write_byte(8'hEE);
        baud_tick = 1;
        for (int i = 0; i < 16; i++) begin
            wait_fall(t1);
            decode(8, 0, got, pg, sl, st);
            chk("R8 fifo order", got, 8'(8'h30 + i));
        end
        quiet = 1;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 0;
        end
        chk("R8 dropped write not sent", quiet, 1);

        // R11 and R8 character mode: no ticks, single holding entry
        fifo_mode = 0; baud_tick = 0;
        write_byte(8'h5A);
        chk("R8 holding full ready", tx_ready, 0);
        write_byte(8'hC3);
        quiet = 1;
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 0;
        end
        chk("R11 no tick no start", quiet, 1);
        chk("R11 byte still held", tx_ready, 0);
        baud_tick = 1;
        wait_fall(t1);
        decode(8, 0, got, pg, sl, st);
        chk("R8 first byte sent", got, 8'h5A);
        quiet = 1;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 0;
        end
        chk("R8 write while full dropped", quiet, 1);

        // R6 start latency and R9 interrupt timing
        @(negedge clk);
        wr_en = 1; wr_data = 8'h55; t0 = cyc;
        @(negedge clk);
        wr_en = 0;
        chk("R9 write clears irq", thr_irq, 0);
        wait_fall(t1);
        chk("R6 start within 8..24 ticks", ((t1 - t0) >= 8) && ((t1 - t0) <= 25), 1);
        wait_to(t1 + 151);
        chk("R9 irq before stop+8", thr_irq, 0);
        @(negedge clk);
        chk("R9 irq at stop+8", thr_irq, 1);
        repeat (40) @(negedge clk);

        // R9 same-cycle write and interrupt rise, R7 no gap
        write_byte(8'h99);
        wait_fall(t1);
        wait_to(t1 + 151);
        wr_en = 1; wr_data = 8'h0F;
        @(negedge clk);
        wr_en = 0;
        chk("R9 write wins over rise", thr_irq, 0);
        wait_fall(t2);
        chk("R7 no idle gap", t2 - t1, 160);
        decode(8, 0, got, pg, sl, st);
        chk("R7 queued byte", got, 8'h0F);
        wait_to(t2 + 153);
        chk("R9 irq after last frame", thr_irq, 1);
        repeat (40) @(negedge clk);

        // R10 break over a frame in flight
        write_byte(8'hFF);
        wait_fall(t1);
        wait_to(t1 + 20);
        break_en = 1;
        wait_to(t1 + 40);
        chk("R10 line low in break", txd, 0);
        wait_to(t1 + 60);
        break_en = 0;
        wait_to(t1 + 72);
        chk("R10 data bit after release", txd, 1);
        wait_to(t1 + 151);
        chk("R10 stop level aligned", txd, 1);
        chk("R10 irq not yet", thr_irq, 0);
        @(negedge clk);
        chk("R10 irq at aligned stop+8", thr_irq, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule